// File: doc/BRIEF.md
# Credit-Based Transmit Channel Status Unit

This block keeps the configuration, status and error state of a set of transmit DMA channels (eight by default) that feed transmit FIFOs under a credit scheme. Software sets, for each channel, a run mode and a credit-enable bit through a simple register port. The scheduler loads a channel's single-entry request buffer with an activate strobe, and the transfer engine reports each issued transfer, marking whether it ends a frame. The FIFO side returns credits one at a time and raises a per-channel full indication.

From this state the block drives a per-channel request line towards the transfer engine. It also drives a per-channel idle line and presents buffer-empty and no-pending bits in a status word. Two error conditions are latched per channel: a credit desynchronisation, where the FIFO reports full while the channel still holds credit, and an activate command that arrives while the request buffer is still occupied. Two global error strobes are latched as well. Every error flag stays set until software writes 1 to it. Reads are combinational from the registered state. Writes and events take effect at the next rising clock edge.

Top module: `txch_credit_stat`

## Requirements
- R1: Addresses 0 to NCH-1 are the channel configuration registers. Bits 31:30 hold the mode (00 off, 01 pause at end of frame, 10 normal, 11 treated as off). Bit 3 is credit enable. All other bits read 0. All of them reset to 0.
- R2: Each channel has a credit counter of CW bits (default 4), read at address 2*NCH+i in the low bits. A credit return adds 1 and an issued transfer subtracts 1. Both in the same cycle leave the counter unchanged. The counter saturates at 0 and at 2^CW-1.
- R3: chan_req[i] is 1 only when three things hold. The request buffer is occupied. Credit enable is 0 or the counter is nonzero. The mode is 10, or the mode is 01 while the channel is mid-frame. Modes 00 and 11 never request.
- R4: An activate strobe fills the request buffer, and an issue strobe empties it; activate wins if both occur in the same cycle. An issue with issue_last=0 marks the channel mid-frame, and an issue with issue_last=1 ends the frame.
- R5: The status word at address NCH has bit 24+i = buffer empty and bit 16+i = no pending request (the inverse of chan_req[i]). All other bits are 0, and writes to this address have no effect.
- R6: chan_idle[i] is 1 exactly when both the buffer-empty and no-pending bits of channel i are set.
- R7: Error bit i (address NCH+1) is set when fifo_full[i] is high while channel i's counter is nonzero.
- R8: Error bit 9+i is set when activate arrives for channel i while its request buffer is already occupied.
- R9: Error bit 31 is set by the mem_addr_err strobe. Error bit 30 is set by the dword_short strobe.
- R10: Writing 1 to an error bit at address NCH+1 clears it, and writing 0 leaves it. An event in the same cycle as the clear keeps the bit set. Unused error bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 32 | Read data, combinational |
| act | input | NCH | Scheduler activate strobe per channel |
| issue | input | NCH | Transfer issued strobe per channel |
| issue_last | input | NCH | Issued transfer ends its frame |
| credit_ret | input | NCH | FIFO credit return strobe per channel |
| fifo_full | input | NCH | FIFO full indication per channel |
| mem_addr_err | input | 1 | Internal memory address error strobe |
| dword_short | input | 1 | Host delivered fewer dwords than expected |
| chan_req | output | NCH | Request towards the transfer engine |
| chan_idle | output | NCH | Channel idle |

## Verification
The bench drives credit returns past the ceiling and issues past zero. A counter that wraps instead of saturating would read 0 after overflow or 15 after underflow. It sets up an error event in the same cycle as a write-1-to-clear. A design that gives the clear priority would lose the flag. It also sends a second activate to an occupied buffer, and it sets a pause-at-end-of-frame channel with and without an open frame, where a wrong decode would request when it should hold or hold when it should request. Long runs of random stimulus, with random register writes that include reserved bits and the read-only status address, are compared against a model built from the requirements.

// File: rtl/txch_credit_stat.sv
module txch_credit_stat #(
  parameter int NCH = 8,
  parameter int CW  = 4,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [31:0]    rd_data,
  input  logic [NCH-1:0] act,
  input  logic [NCH-1:0] issue,
  input  logic [NCH-1:0] issue_last,
  input  logic [NCH-1:0] credit_ret,
  input  logic [NCH-1:0] fifo_full,
  input  logic           mem_addr_err,
  input  logic           dword_short,
  output logic [NCH-1:0] chan_req,
  output logic [NCH-1:0] chan_idle
);
  localparam int STS_ADDR = NCH;
  localparam int ERR_ADDR = NCH + 1;
  localparam int CRD_BASE = 2 * NCH;
  localparam logic [CW-1:0] CMAX = '1;

  logic [NCH-1:0][1:0]    mode;
  logic [NCH-1:0]         cen;
  logic [NCH-1:0][CW-1:0] cred;
  logic [NCH-1:0]         occ, infr;
  logic [NCH-1:0]         err_cr, err_act;
  logic                   err_mem, err_dw;
  logic [NCH-1:0]         has_cred;
  logic                   clr;
  logic [31:0]            sts_word, err_word;
  logic                   unused_wdata;

  assign clr = wr_en && (wr_addr == AW'(ERR_ADDR));
  assign unused_wdata = ^wr_data;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign has_cred[g]  = !cen[g] || (cred[g] != '0);
    assign chan_req[g]  = occ[g] && has_cred[g] &&
                          ((mode[g] == 2'b10) || ((mode[g] == 2'b01) && infr[g]));
    assign chan_idle[g] = !occ[g] && !chan_req[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= '0;
      cen     <= '0;
      cred    <= '0;
      occ     <= '0;
      infr    <= '0;
      err_cr  <= '0;
      err_act <= '0;
      err_mem <= 1'b0;
      err_dw  <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_en && (wr_addr == AW'(i))) begin
          mode[i] <= wr_data[31:30];
          cen[i]  <= wr_data[3];
        end
        if (credit_ret[i] && !issue[i] && (cred[i] != CMAX))
          cred[i] <= cred[i] + 1'b1;
        else if (issue[i] && !credit_ret[i] && (cred[i] != '0))
          cred[i] <= cred[i] - 1'b1;
        if (act[i])
          occ[i] <= 1'b1;
        else if (issue[i])
          occ[i] <= 1'b0;
        if (issue[i])
          infr[i] <= !issue_last[i];
        err_cr[i]  <= (fifo_full[i] && (cred[i] != '0)) ||
                      (err_cr[i] && !(clr && wr_data[i]));
        err_act[i] <= (act[i] && occ[i]) ||
                      (err_act[i] && !(clr && wr_data[9+i]));
      end
      err_mem <= mem_addr_err || (err_mem && !(clr && wr_data[31]));
      err_dw  <= dword_short  || (err_dw  && !(clr && wr_data[30]));
    end
  end

  always_comb begin
    sts_word = '0;
    err_word = '0;
    for (int i = 0; i < NCH; i++) begin
      sts_word[24+i] = !occ[i];
      sts_word[16+i] = !chan_req[i];
      err_word[i]    = err_cr[i];
      err_word[9+i]  = err_act[i];
    end
    err_word[31] = err_mem;
    err_word[30] = err_dw;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(i))
        rd_data = {mode[i], 26'b0, cen[i], 3'b0};
      if (rd_addr == AW'(CRD_BASE + i))
        rd_data = 32'(cred[i]);
    end
    if (rd_addr == AW'(STS_ADDR)) rd_data = sts_word;
    if (rd_addr == AW'(ERR_ADDR)) rd_data = err_word;
  end
endmodule

module txch_credit_stat_chk #(
  parameter int NCH = 8,
  parameter int CW  = 4,
  parameter int AW  = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [31:0]            wr_data,
  input logic [NCH-1:0]         act,
  input logic [NCH-1:0]         issue,
  input logic [NCH-1:0]         credit_ret,
  input logic [NCH-1:0]         fifo_full,
  input logic [NCH-1:0]         chan_req,
  input logic [NCH-1:0]         chan_idle,
  input logic [NCH-1:0][1:0]    mode,
  input logic [NCH-1:0][CW-1:0] cred,
  input logic [NCH-1:0]         occ,
  input logic [NCH-1:0]         err_cr,
  input logic [NCH-1:0]         err_act
);
  localparam int ERR_ADDR = NCH + 1;
  localparam logic [CW-1:0] CMAX = '1;

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_cred_ceiling_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cred[g] == CMAX && credit_ret[g] && !issue[g]) |=> (cred[g] == CMAX));
    assert_cred_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cred[g] == '0 && issue[g] && !credit_ret[g]) |=> (cred[g] == '0));
    assert_req_needs_buf_R3: assert property (@(posedge clk) disable iff (!rst_n)
      chan_req[g] |-> (occ[g] && mode[g] != 2'b00 && mode[g] != 2'b11));
    assert_idle_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_idle[g] |-> !occ[g]);
    assert_desync_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full[g] && cred[g] != '0) |=> err_cr[g]);
    assert_act_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (act[g] && occ[g]) |=> err_act[g]);
    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cr[g] && !(wr_en && wr_addr == AW'(ERR_ADDR) && wr_data[g])) |=> err_cr[g]);
  end
endmodule

bind txch_credit_stat txch_credit_stat_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .act(act), .issue(issue), .credit_ret(credit_ret), .fifo_full(fifo_full),
  .chan_req(chan_req), .chan_idle(chan_idle), .mode(mode), .cred(cred),
  .occ(occ), .err_cr(err_cr), .err_act(err_act)
);

// File: tb/test_txch_credit_stat.sv
`timescale 1ns/1ps
module test_txch_credit_stat;
  localparam int N = 8;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [N-1:0] act, issue, issue_last, credit_ret, fifo_full, chan_req, chan_idle;
  logic mem_addr_err, dword_short;

  int n_chk = 0, n_bad = 0;

  logic [1:0] m_mode [N];
  logic       m_cen  [N];
  int         m_cred [N];
  logic       m_occ  [N], m_infr [N], m_ecr [N], m_eact [N];
  logic       m_emem, m_edw;

  txch_credit_stat #(.NCH(N), .CW(4), .AW(AW)) i_txch_credit_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .act(act), .issue(issue),
    .issue_last(issue_last), .credit_ret(credit_ret), .fifo_full(fifo_full),
    .mem_addr_err(mem_addr_err), .dword_short(dword_short),
    .chan_req(chan_req), .chan_idle(chan_idle)
  );

  always #4 clk = ~clk;

  function automatic logic exp_req(int i);
    return m_occ[i] && (!m_cen[i] || m_cred[i] != 0) &&
           (m_mode[i] == 2'b10 || (m_mode[i] == 2'b01 && m_infr[i]));
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    logic [31:0] v = '0;
    if (a < N) begin v[31:30] = m_mode[a]; v[3] = m_cen[a]; end
    else if (a == N) begin
      for (int i = 0; i < N; i++) begin v[24+i] = !m_occ[i]; v[16+i] = !exp_req(i); end
    end else if (a == N + 1) begin
      for (int i = 0; i < N; i++) begin v[i] = m_ecr[i]; v[9+i] = m_eact[i]; end
      v[31] = m_emem; v[30] = m_edw;
    end else if (a >= 2*N && a < 3*N) v = 32'(m_cred[a-2*N]);
    return v;
  endfunction

  function automatic string tag_of(int a);
    if (a < N) return "R1";
    if (a == N) return "R5";
    if (a == N + 1) return "R10";
    if (a >= 2*N && a < 3*N) return "R2";
    return "R10";
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_rd(int a, string tag);
    rd_addr = AW'(a);
    #1;
    chk(tag, rd_data, exp_rd(a));
  endtask

  task automatic chk_lines();
    logic [N-1:0] er, ei;
    for (int i = 0; i < N; i++) begin
      er[i] = exp_req(i);
      ei[i] = !m_occ[i] && !exp_req(i);
    end
    chk("R3", 32'(chan_req), 32'(er));
    chk("R6", 32'(chan_idle), 32'(ei));
  endtask

  task automatic zero_in();
    wr_en = 0; wr_addr = '0; wr_data = '0; act = '0; issue = '0; issue_last = '0;
    credit_ret = '0; fifo_full = '0; mem_addr_err = 0; dword_short = 0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_mode[i] = 0; m_cen[i] = 0; m_cred[i] = 0; m_occ[i] = 0;
      m_infr[i] = 0; m_ecr[i] = 0; m_eact[i] = 0;
    end
    m_emem = 0; m_edw = 0;
  endtask

  task automatic tick();
    logic clr = wr_en && (wr_addr == AW'(N + 1));
    for (int i = 0; i < N; i++) begin
      m_ecr[i]  = (fifo_full[i] && m_cred[i] != 0) || (m_ecr[i] && !(clr && wr_data[i]));
      m_eact[i] = (act[i] && m_occ[i]) || (m_eact[i] && !(clr && wr_data[9+i]));
      if (credit_ret[i] && !issue[i] && m_cred[i] < 15) m_cred[i]++;
      else if (issue[i] && !credit_ret[i] && m_cred[i] > 0) m_cred[i]--;
      if (act[i]) m_occ[i] = 1; else if (issue[i]) m_occ[i] = 0;
      if (issue[i]) m_infr[i] = !issue_last[i];
      if (wr_en && wr_addr == AW'(i)) begin m_mode[i] = wr_data[31:30]; m_cen[i] = wr_data[3]; end
    end
    m_emem = mem_addr_err || (m_emem && !(clr && wr_data[31]));
    m_edw  = dword_short  || (m_edw  && !(clr && wr_data[30]));
    @(posedge clk);
    @(negedge clk);
    zero_in();
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    tick();
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_0042));
    zero_in();
    rd_addr = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // reset state: R1 R2 R5 R6 R10
    for (int a = 0; a < 3*N; a++) chk_rd(a, tag_of(a));
    chk("R6", 32'(chan_idle), 32'hFF);

    // R1 reserved bits dropped
    wr(1, 32'hFFFF_FFFF);
    rd_addr = AW'(1); #1; chk("R1", rd_data, 32'hC000_0008);

    // R2 ceiling and floor
    for (int k = 0; k < 20; k++) begin credit_ret[2] = 1; tick(); end
    rd_addr = AW'(2*N+2); #1; chk("R2", rd_data, 32'd15);
    credit_ret[2] = 1; issue[2] = 1; tick();
    rd_addr = AW'(2*N+2); #1; chk("R2", rd_data, 32'd15);
    for (int k = 0; k < 20; k++) begin issue[2] = 1; issue_last[2] = 1; tick(); end
    rd_addr = AW'(2*N+2); #1; chk("R2", rd_data, 32'd0);

    // R8 activate into occupied buffer, R10 clear vs event
    act[3] = 1; tick();
    act[3] = 1; tick();
    chk_rd(N+1, "R8");
    act[3] = 1; wr(N+1, 32'h0000_1000);
    chk_rd(N+1, "R10");
    wr(N+1, 32'h0000_1000);
    rd_addr = AW'(N+1); #1; chk("R10", rd_data & 32'h0000_1000, 32'h0);

    // R7 desync
    credit_ret[4] = 1; tick();
    fifo_full[4] = 1; tick();
    chk_rd(N+1, "R7");
    fifo_full[5] = 1; tick();
    rd_addr = AW'(N+1); #1; chk("R7", rd_data & 32'h20, 32'h0);

    // R9 global strobes
    mem_addr_err = 1; tick();
    dword_short = 1; tick();
    rd_addr = AW'(N+1); #1; chk("R9", rd_data & 32'hC000_0000, 32'hC000_0000);
    wr(N+1, 32'hFFFF_FFFF);
    chk_rd(N+1, "R10");

    // R3/R4 pause-at-end-of-frame
    wr(5, 32'h4000_0000);
    act[5] = 1; tick();
    chk_lines();
    issue[5] = 1; issue_last[5] = 0; tick();
    act[5] = 1; tick();
    chk("R4", 32'(chan_req[5]), 32'd1);
    issue[5] = 1; issue_last[5] = 1; tick();
    act[5] = 1; tick();
    chk("R4", 32'(chan_req[5]), 32'd0);
    chk_lines();

    // R5 status write ignored
    chk_rd(N, "R5");
    wr(N, 32'h0);
    chk_rd(N, "R5");

    // R3 credit gating in normal mode
    wr(6, 32'h8000_0008);
    act[6] = 1; tick();
    chk("R3", 32'(chan_req[6]), 32'd0);
    credit_ret[6] = 1; tick();
    chk("R3", 32'(chan_req[6]), 32'd1);

    // random
    for (int s = 0; s < 4000; s++) begin
      for (int i = 0; i < N; i++) begin
        act[i] = ($urandom % 4) == 0;
        issue[i] = ($urandom % 4) == 0;
        issue_last[i] = ($urandom % 2) == 0;
        credit_ret[i] = ($urandom % 3) == 0;
        fifo_full[i] = ($urandom % 8) == 0;
      end
      mem_addr_err = ($urandom % 32) == 0;
      dword_short = ($urandom % 32) == 0;
      if (($urandom % 5) == 0) begin
        wr_en = 1;
        wr_addr = AW'($urandom % (N + 2));
        wr_data = $urandom;
      end
      tick();
      begin
        int a = $urandom % 32;
        chk_rd(a, tag_of(a));
      end
      chk_lines();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule